// File: doc/BRIEF.md
# Bit-Band Alias Bridge

The bridge answers a 32 MiB alias window in which every aligned 32-bit word stands for a single bit of a 1 MiB underlying memory region. An upstream requester reads or writes an alias word. The bridge turns that access into a downstream access to the real bytes that hold the bit. A read returns the addressed bit alone in bit 0 of the read data. A write becomes an uninterrupted read-modify-write that sets or clears only that bit.

The underlying region base is a parameter. A system would place one instance per banded region, for example with the underlying region at 0x2000_0000 and the alias window at 0x2200_0000, or with the underlying region at 0x4000_0000 and the alias window at 0x4200_0000. The bridge decodes only the low 25 address bits, which form the offset within the window. Decoding of the window itself is left to the surrounding fabric.

Both ports use the same handshake. The requester raises its request and holds the fields stable until the responder gives a one-cycle ready pulse. The bridge handles one transaction at a time. It reports an error to the requester if either downstream phase returns one.

Top module: `bitband_bridge`

## Requirements
- R1: The downstream address is BASE_ADDR OR'd with alias offset bits [24:5], aligned down to a multiple of the access size. Address bits [31:25] have no effect. The address stays stable for the whole transaction, including across both phases of a read-modify-write.
- R2: Size code `upSize` is 0 for 1 byte, 1 for 2 bytes and 2 for 4 bytes. All three are accepted for reads and for writes, and the same code is driven on `dnSize`.
- R3: The bit index is offset bits [4:2] for 1-byte accesses, [5:2] for 2-byte accesses and [6:2] for 4-byte accesses. Downstream data is little-endian: byte k of the access sits in data bits [8k+7:8k], and the bit is index[2:0] of byte index>>3. A read returns that bit in `upRdata[0]`, with bits [31:1] zero, and issues no downstream write.
- R4: A write reads the aligned bytes and then writes the same address and size back. In the write-back the selected bit equals `upWdata[0]`, and every other bit keeps its value. The read data on a write response is zero.
- R5: `upReady` is a single-cycle pulse. It comes only after the last downstream phase has completed. `dnReq` stays high, with its direction held, until `dnReady`, and it is low while no transaction is in progress.
- R6: An error on the downstream read ends the transaction with `upErr` = 1 and no downstream write.
- R7: An error on the downstream write-back is returned as `upErr` = 1 for that write. A transaction with no downstream error responds with `upErr` = 0.
- R8: During reset `upReady` and `dnReq` are low.
- R9: A downstream write is issued only directly after a successful downstream read of the same transaction, with no other downstream access in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| upReq | input | 1 | Upstream request, held until `upReady` |
| upWrite | input | 1 | 1 = write, 0 = read |
| upAddr | input | ADDR_W | Alias address; only bits [WIN_W-1:0] are decoded |
| upSize | input | 2 | Access size code (0 = 1 B, 1 = 2 B, 2 = 4 B) |
| upWdata | input | 32 | Write data; bit 0 is the new bit value |
| upReady | output | 1 | One-cycle completion pulse |
| upRdata | output | 32 | Read result, valid with `upReady` |
| upErr | output | 1 | Error response, valid with `upReady` |
| dnReq | output | 1 | Downstream request |
| dnWrite | output | 1 | Downstream direction, 1 = write |
| dnAddr | output | ADDR_W | Downstream byte address |
| dnSize | output | 2 | Downstream size code |
| dnWdata | output | 32 | Downstream write data |
| dnReady | input | 1 | Downstream completion pulse |
| dnRdata | input | 32 | Downstream read data |
| dnErr | input | 1 | Downstream error, valid with `dnReady` |

## Verification
The request is captured on the first edge at which it is seen, and `dnReq` rises in the following cycle. After the downstream `dnReady` pulse that ends the read phase, a read finishes with `upReady` one cycle later. For a write, the write-back request starts in that cycle instead, and `upReady` comes one cycle after the write-back's `dnReady`. The bench drives all stimulus and downstream responses on the falling edge. It polls `upReady` there, takes the result on the falling edge where `upReady` is seen high, and drops the request on that same edge. The downstream model records each phase's address, size and data as it responds, and these records are compared once the upstream response has been taken. The downstream latency is varied from zero to two extra cycles, so the checks do not depend on fixed timing.

// File: rtl/bb_pkg.sv
package bb_pkg;
  localparam int DATA_W = 32;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RD,
    ST_WR,
    ST_RESP
  } bbState_t;

  typedef struct packed {
    logic capture;
    logic loadRd;
  } dpCtl_t;
endpackage

// File: rtl/bb_ctrl.sv
module bb_ctrl
  import bb_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   upReq,
  input  logic   upWrite,
  input  logic   dnReady,
  input  logic   dnErr,
  output logic   upReady,
  output logic   upErr,
  output logic   dnReq,
  output logic   dnWrite,
  output dpCtl_t ctl
);
  bbState_t state;
  logic     isWr;
  logic     errQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      isWr  <= 1'b0;
      errQ  <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (upReq) begin
          state <= ST_RD;
          isWr  <= upWrite;
          errQ  <= 1'b0;
        end
        ST_RD: if (dnReady) begin
          errQ  <= dnErr;
          state <= (dnErr || !isWr) ? ST_RESP : ST_WR;
        end
        ST_WR: if (dnReady) begin
          errQ  <= dnErr;
          state <= ST_RESP;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    dnReq       = (state == ST_RD) || (state == ST_WR);
    dnWrite     = (state == ST_WR);
    upReady     = (state == ST_RESP);
    upErr       = (state == ST_RESP) && errQ;
    ctl.capture = (state == ST_IDLE) && upReq;
    ctl.loadRd  = (state == ST_RD) && dnReady;
  end

  AST_NO_WR_ON_RDERR: assert property (@(posedge clk) disable iff (!rstN)
    (dnReq && !dnWrite && dnReady && dnErr) |=> !dnReq); // R6
  AST_WR_AFTER_GOOD_RD: assert property (@(posedge clk) disable iff (!rstN)
    (dnReq && dnWrite && !$past(dnReq && dnWrite)) |-> $past(dnReady && !dnErr && !dnWrite)); // R9
  AST_READY_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    upReady |=> !upReady); // R5
  AST_READY_AFTER_DN: assert property (@(posedge clk) disable iff (!rstN)
    upReady |-> $past(dnReady)); // R5
  AST_HOLD_REQ: assert property (@(posedge clk) disable iff (!rstN)
    (dnReq && !dnReady) |=> (dnReq && $stable(dnWrite))); // R5
endmodule

// File: rtl/bb_datapath.sv
module bb_datapath
  import bb_pkg::*;
#(
  parameter int              ADDR_W    = 32,
  parameter int              WIN_W     = 25,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 32'h2000_0000
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic [WIN_W-1:0]  offIn,
  input  logic [1:0]        sizeIn,
  input  logic              writeIn,
  input  logic              bitIn,
  input  logic [DATA_W-1:0] dnRdata,
  input  logic              dnReq,
  input  logic              dnWrite,
  output logic [ADDR_W-1:0] dnAddr,
  output logic [1:0]        dnSize,
  output logic [DATA_W-1:0] dnWdata,
  output logic [DATA_W-1:0] upRdata
);
  localparam int IDX_W = $clog2(DATA_W);

  logic [WIN_W-1:0]  offQ;
  logic [1:0]        sizeQ;
  logic              wrQ;
  logic              bitQ;
  logic [DATA_W-1:0] rdBuf;
  logic [IDX_W-1:0]  bitIdx;
  logic [ADDR_W-1:0] alignMask;
  logic [DATA_W-1:0] laneMask;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      offQ  <= '0;
      sizeQ <= '0;
      wrQ   <= 1'b0;
      bitQ  <= 1'b0;
      rdBuf <= '0;
    end else begin
      if (ctl.capture) begin
        offQ  <= offIn;
        sizeQ <= sizeIn;
        wrQ   <= writeIn;
        bitQ  <= bitIn;
      end
      if (ctl.loadRd) rdBuf <= dnRdata;
    end
  end

  always_comb begin
    case (sizeQ)
      2'd0: begin
        bitIdx    = {2'b00, offQ[4:2]};
        alignMask = ADDR_W'(0);
        laneMask  = DATA_W'(32'h0000_00FF);
      end
      2'd1: begin
        bitIdx    = {1'b0, offQ[5:2]};
        alignMask = ADDR_W'(1);
        laneMask  = DATA_W'(32'h0000_FFFF);
      end
      default: begin
        bitIdx    = offQ[6:2];
        alignMask = ADDR_W'(3);
        laneMask  = '1;
      end
    endcase
    dnAddr  = (BASE_ADDR | ADDR_W'(offQ[WIN_W-1:5])) & ~alignMask;
    dnSize  = sizeQ;
    dnWdata = rdBuf;
    dnWdata[bitIdx] = bitQ;
    upRdata = '0;
    upRdata[0] = wrQ ? 1'b0 : rdBuf[bitIdx];
  end

  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (dnReq && $past(dnReq)) |-> $stable(dnAddr)); // R1
  AST_ONE_BIT_CHANGE: assert property (@(posedge clk) disable iff (!rstN)
    (dnReq && dnWrite) |-> ($countones((dnWdata ^ rdBuf) & laneMask) <= 1)); // R4
endmodule

// File: rtl/bitband_bridge.sv
module bitband_bridge
  import bb_pkg::*;
#(
  parameter int                ADDR_W    = 32,
  parameter int                WIN_W     = 25,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 32'h2000_0000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              upReq,
  input  logic              upWrite,
  input  logic [ADDR_W-1:0] upAddr,
  input  logic [1:0]        upSize,
  input  logic [31:0]       upWdata,
  output logic              upReady,
  output logic [31:0]       upRdata,
  output logic              upErr,
  output logic              dnReq,
  output logic              dnWrite,
  output logic [ADDR_W-1:0] dnAddr,
  output logic [1:0]        dnSize,
  output logic [31:0]       dnWdata,
  input  logic              dnReady,
  input  logic [31:0]       dnRdata,
  input  logic              dnErr
);
  dpCtl_t ctl;
  logic   unusedBits;

  assign unusedBits = ^{upWdata[31:1], upAddr[ADDR_W-1:WIN_W]};

  bb_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .upReq   (upReq),
    .upWrite (upWrite),
    .dnReady (dnReady),
    .dnErr   (dnErr),
    .upReady (upReady),
    .upErr   (upErr),
    .dnReq   (dnReq),
    .dnWrite (dnWrite),
    .ctl     (ctl)
  );

  bb_datapath #(
    .ADDR_W    (ADDR_W),
    .WIN_W     (WIN_W),
    .BASE_ADDR (BASE_ADDR)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .ctl     (ctl),
    .offIn   (upAddr[WIN_W-1:0]),
    .sizeIn  (upSize),
    .writeIn (upWrite),
    .bitIn   (upWdata[0]),
    .dnRdata (dnRdata),
    .dnReq   (dnReq),
    .dnWrite (dnWrite),
    .dnAddr  (dnAddr),
    .dnSize  (dnSize),
    .dnWdata (dnWdata),
    .upRdata (upRdata)
  );
endmodule

// File: tb/bitband_bridge_test.sv
module bitband_bridge_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] BASE = 32'h2000_0000;

  typedef struct packed {
    logic        wr;
    logic [1:0]  sz;
    logic [24:0] off;
    logic [31:0] wdat;
  } vec_t;

  localparam int NVEC = 12;
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 2'd2, 25'h0000004, 32'h0},
    '{1'b0, 2'd0, 25'h00001FC, 32'h0},
    '{1'b0, 2'd1, 25'h0000238, 32'h0},
    '{1'b1, 2'd2, 25'h0000474, 32'h1},
    '{1'b0, 2'd2, 25'h0000474, 32'h0},
    '{1'b1, 2'd0, 25'h0000474, 32'h0},
    '{1'b0, 2'd0, 25'h0000474, 32'h0},
    '{1'b1, 2'd1, 25'h0001FE0, 32'h1},
    '{1'b0, 2'd2, 25'h0001FE0, 32'h0},
    '{1'b1, 2'd2, 25'h0000100, 32'h0},
    '{1'b1, 2'd0, 25'h00000A8, 32'hFFFF_FFFE},
    '{1'b0, 2'd0, 25'h1FFFFFC, 32'h0}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        upReq = 1'b0, upWrite = 1'b0;
  logic [31:0] upAddr = '0, upWdata = '0;
  logic [1:0]  upSize = '0;
  logic        upReady, upErr, dnReq, dnWrite;
  logic [31:0] upRdata, dnAddr, dnWdata;
  logic [1:0]  dnSize;
  logic        dnReady = 1'b0, dnErr = 1'b0;
  logic [31:0] dnRdata = '0;

  logic [7:0]  mem [256];
  logic [7:0]  shadow [256];
  int          lat = 0, cnt = 0;
  logic        errRd = 1'b0, errWr = 1'b0;
  int          wrCount = 0, txnCount = 0;
  logic [31:0] lastRdAddr = '0, lastWrAddr = '0;
  logic [1:0]  lastRdSize = '0;
  int          nTests = 0, nFail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bitband_bridge uut (
    .clk(clk), .rstN(rstN), .upReq(upReq), .upWrite(upWrite), .upAddr(upAddr),
    .upSize(upSize), .upWdata(upWdata), .upReady(upReady), .upRdata(upRdata),
    .upErr(upErr), .dnReq(dnReq), .dnWrite(dnWrite), .dnAddr(dnAddr),
    .dnSize(dnSize), .dnWdata(dnWdata), .dnReady(dnReady), .dnRdata(dnRdata),
    .dnErr(dnErr)
  );

  function automatic int nBytes(input logic [1:0] sz);
    return (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
  endfunction

  // downstream memory model, acts on the falling edge
  always @(negedge clk) begin
    if (!rstN) begin
      dnReady = 1'b0; dnErr = 1'b0; cnt = 0;
    end else if (dnReady) begin
      dnReady = 1'b0; dnErr = 1'b0;
    end else if (dnReq) begin
      if (cnt >= lat) begin
        cnt = 0;
        dnReady = 1'b1;
        txnCount++;
        if (dnWrite) begin
          dnErr = errWr;
          lastWrAddr = dnAddr;
          wrCount++;
          if (!errWr)
            for (int k = 0; k < nBytes(dnSize); k++)
              mem[8'(dnAddr + 32'(k))] = dnWdata[8*k +: 8];
        end else begin
          dnErr = errRd;
          lastRdAddr = dnAddr;
          lastRdSize = dnSize;
          dnRdata = '0;
          for (int k = 0; k < nBytes(dnSize); k++)
            dnRdata[8*k +: 8] = mem[8'(dnAddr + 32'(k))];
        end
      end else begin
        cnt++;
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] refAddr(input logic [1:0] sz, input logic [24:0] off);
    logic [31:0] a;
    a = BASE | 32'(off[24:5]);
    return a & ~(32'(nBytes(sz)) - 32'd1);
  endfunction

  function automatic int refIdx(input logic [1:0] sz, input logic [24:0] off);
    return int'(off >> 2) & (8 * nBytes(sz) - 1);
  endfunction

  task automatic access(input logic wr, input logic [1:0] sz, input logic [31:0] addr,
                        input logic [31:0] wd, output logic [31:0] rd, output logic err);
    int n;
    upReq = 1'b1; upWrite = wr; upSize = sz; upAddr = addr; upWdata = wd;
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!upReady && n < 200);
    if (!upReady) begin
      nTests++; nFail++;
      $display("FAIL R5 no upReady actual=0 expected=1");
    end
    rd = upRdata;
    err = upErr;
    upReq = 1'b0;
  endtask

  task automatic memMatches(input string tag);
    int bad;
    bad = 0;
    for (int i = 0; i < 256; i++) if (mem[i] !== shadow[i]) bad++;
    chk(tag, 32'(bad), 32'd0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    nTests++; nFail++;
    $display("FAIL R5 watchdog actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    logic [31:0] rd, eAddr;
    logic        err, eBit;
    int          eIdx, byteI, preWr, preTx;
    for (int i = 0; i < 256; i++) begin
      mem[i] = 8'(i * 37 + 5);
      shadow[i] = mem[i];
    end

    repeat (3) @(negedge clk);
    chk("R8 upReady in reset", 32'(upReady), 32'd0);
    chk("R8 dnReq in reset", 32'(dnReq), 32'd0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    chk("R5 dnReq quiet when idle", 32'(dnReq), 32'd0);

    for (int v = 0; v < NVEC; v++) begin
      lat = v % 3;
      eAddr = refAddr(VECS[v].sz, VECS[v].off);
      eIdx = refIdx(VECS[v].sz, VECS[v].off);
      byteI = int'(eAddr[7:0]) + (eIdx >> 3);
      eBit = shadow[byteI][eIdx & 7];
      preWr = wrCount;
      preTx = txnCount;
      access(VECS[v].wr, VECS[v].sz, 32'h2200_0000 | 32'(VECS[v].off), VECS[v].wdat, rd, err);
      chk($sformatf("R1 vec%0d read address", v), lastRdAddr, eAddr);
      chk($sformatf("R2 vec%0d size", v), 32'(lastRdSize), 32'(VECS[v].sz));
      chk($sformatf("R7 vec%0d no error", v), 32'(err), 32'd0);
      if (!VECS[v].wr) begin
        chk($sformatf("R3 vec%0d read bit", v), rd, 32'(eBit));
        chk($sformatf("R3 vec%0d no write on read", v), 32'(wrCount - preWr), 32'd0);
      end else begin
        shadow[byteI][eIdx & 7] = VECS[v].wdat[0];
        chk($sformatf("R4 vec%0d write-back address", v), lastWrAddr, eAddr);
        chk($sformatf("R9 vec%0d two downstream phases", v), 32'(txnCount - preTx), 32'd2);
        chk($sformatf("R4 vec%0d rdata zero", v), rd, 32'd0);
        memMatches($sformatf("R4 vec%0d memory contents", v));
      end
    end

    // upper address bits ignored
    lat = 1;
    eAddr = refAddr(2'd0, 25'h00001FC);
    access(1'b0, 2'd0, 32'hFE00_01FC, 32'h0, rd, err);
    chk("R1 upper bits ignored", lastRdAddr, eAddr);
    chk("R3 upper bits ignored bit", rd, 32'(shadow[int'(eAddr[7:0])][7]));

    // read error during a write: no write-back
    errRd = 1'b1;
    preWr = wrCount;
    access(1'b1, 2'd2, 32'h2200_0004, 32'h1, rd, err);
    errRd = 1'b0;
    chk("R6 read error reported", 32'(err), 32'd1);
    chk("R6 no write after read error", 32'(wrCount - preWr), 32'd0);
    memMatches("R6 memory untouched");

    // read error on plain read
    errRd = 1'b1;
    access(1'b0, 2'd1, 32'h2200_0238, 32'h0, rd, err);
    errRd = 1'b0;
    chk("R6 read error on read", 32'(err), 32'd1);

    // write-back error
    lat = 0;
    errWr = 1'b1;
    preWr = wrCount;
    access(1'b1, 2'd0, 32'h2200_0300, 32'h1, rd, err);
    errWr = 1'b0;
    chk("R7 write-back error reported", 32'(err), 32'd1);
    chk("R7 write-back was attempted", 32'(wrCount - preWr), 32'd1);

    // clean access after errors
    access(1'b0, 2'd2, 32'h2200_0474, 32'h0, rd, err);
    chk("R7 error cleared", 32'(err), 32'd0);
    chk("R3 bit after errors", rd, 32'(shadow[8'h23][5]));

    @(negedge clk);
    chk("R5 idle after run", 32'(dnReq), 32'd0);

    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule